// File: doc/BRIEF.md
# Write-Masked GPIO Register Bank

This block is the configuration and readback register file of a 32-pin general-purpose I/O port. Every 32-bit logical register is held as two 16-bit halves at neighbouring word addresses. Each half is written with a single bus write that carries its own per-bit enables. The upper 16 bits of the write data select which of the lower 16 data bits take effect. Software can therefore set or clear one pin without first reading the register, and two agents that touch different pins never overwrite each other.

The bank holds the output data, the pin direction, and the configuration words that the interrupt and debounce logic consume. It also holds a 32-bit debounce divider word, which is written whole. It lets software read the live pin inputs, the interrupt status and raw status supplied by neighbouring logic, and a fixed version identifier. A write to the end-of-interrupt location does not store anything. It produces a one-cycle acknowledge pulse on the enabled bits. The bus side is a plain read/write port with a word address. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_wm_bank`

## Requirements
- R1: After reset every stored register is 0, all configuration outputs are 0 (every pin an input, no interrupt enabled), and `rd_data` is 0.
- R2: A write to a masked half updates data bit k (k = 0..15, `wr_data[k]`) only when enable bit `wr_data[k+16]` is 1. Bits whose enable is 0 keep their old value.
- R3: A data bit written 0 with its enable set is cleared, so a single pin can be cleared without touching the others.
- R4: Masked register n (n = 0..8) keeps pins 0-15 at word address 2n and pins 16-31 at word address 2n+1. A read of either half returns its 16 bits in `rd_data[15:0]`, with bits 31:16 equal to 0.
- R5: `rd_data` carries the value selected by the read in the cycle after `rd_en`, and is 0 in any cycle that follows a cycle without `rd_en`.
- R6: Word address 30 reads the constant 0x01000C2B, and writes to that address change nothing.
- R7: Word addresses 28 and 29 read `pin_in[15:0]` and `pin_in[31:16]`, and writes to them change nothing.
- R8: Word address 18 is a 32-bit divider register. It takes all 32 write bits with no enable scheme, drives `dbc_div`, and reads back whole.
- R9: Reads of unmapped word addresses (19, 26, 27, 31) return 0.
- R10: Word addresses 20/21 read the low/high half of `irq_status_in`, and 22/23 read the low/high half of `irq_raw_in`.
- R11: A write to word address 24 (low half) or 25 (high half) makes `eoi_pulse` high for exactly one cycle on the bits whose enable and data bits are both 1. Reads of these addresses return 0.
- R12: The masked registers drive, in index order 0..8: `pin_out`, `pin_dir` (1 = output), `irq_en`, `irq_mask`, `irq_type`, `irq_pol`, `irq_both`, `dbc_en`, `dbc_div_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address (byte offset / 4) |
| wr_data | input | 32 | Write data: enables in 31:16, data in 15:0 |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 32 | Live pin input levels |
| irq_status_in | input | 32 | Masked interrupt status from interrupt logic |
| irq_raw_in | input | 32 | Raw interrupt status from interrupt logic |
| pin_out | output | 32 | Output data register |
| pin_dir | output | 32 | Direction, 1 = output |
| irq_en | output | 32 | Interrupt enable |
| irq_mask | output | 32 | Interrupt mask |
| irq_type | output | 32 | Interrupt level/edge type |
| irq_pol | output | 32 | Interrupt polarity |
| irq_both | output | 32 | Interrupt on both edges |
| dbc_en | output | 32 | Debounce enable |
| dbc_div_en | output | 32 | Debounce divider enable |
| dbc_div | output | 32 | Debounce divider value |
| eoi_pulse | output | 32 | One-cycle end-of-interrupt acknowledge |

## Verification
The assertions assume that `rst` is held for at least one clock at start-up. They also assume that `pin_in` and the two status inputs hold known values whenever a read may select them. Reads and writes may share a cycle, and a read then returns the value from before the write. The directed stimulus applies each strobe for a single cycle between falling edges and keeps every input driven to a defined value from time zero. It never leaves an address or data bit unknown while a strobe is high.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int WORD_W     = 5;
  localparam int PAIR_W     = WORD_W - 1;
  localparam int NUM_MASKED = 9;

  // masked register index order
  localparam int IDX_OUT    = 0;
  localparam int IDX_DIR    = 1;
  localparam int IDX_IEN    = 2;
  localparam int IDX_IMSK   = 3;
  localparam int IDX_ITYP   = 4;
  localparam int IDX_IPOL   = 5;
  localparam int IDX_IBOTH  = 6;
  localparam int IDX_DBEN   = 7;
  localparam int IDX_DBDEN  = 8;

  // pair indices (word address >> 1) for the other locations
  localparam int PAIR_DIV   = 9;
  localparam int PAIR_STAT  = 10;
  localparam int PAIR_RAW   = 11;
  localparam int PAIR_EOI   = 12;
  localparam int PAIR_EXT   = 14;
  localparam int WORD_DIV   = 18;
  localparam int WORD_VER   = 30;

  localparam logic [DATA_W-1:0] VERSION_ID = 32'h0100_0C2B;

  typedef logic [NUM_MASKED-1:0][DATA_W-1:0] cfg_arr_t;

  // readable word addresses, listed independently of the read mux
  function automatic logic word_readable(input int w);
    return (w <= 18) || (w >= 20 && w <= 23) || (w == 28) || (w == 29) || (w == 30);
  endfunction
endpackage

// File: rtl/gpio_wm_half.sv
module gpio_wm_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= (q & ~mask) | (data & mask);
  end

  // R1: reset leaves the half cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == '0);
  // R2: bits without enable survive a write
  p_keep_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q ^ $past(q)) & ~$past(mask)) == '0);
  // R2: no write, no change
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
  // R3: enabled zero bits end up cleared
  p_clear_bit_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> (q & $past(mask & ~data)) == '0);
endmodule

// File: rtl/gpio_wm_rdmux.sv
module gpio_wm_rdmux
  import gpio_wm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] addr,
  input  cfg_arr_t          cfg,
  input  logic [DATA_W-1:0] div,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] ext,
  output logic [DATA_W-1:0] rd_data
);
  logic [PAIR_W-1:0] pair;
  logic              hi;
  logic [DATA_W-1:0] pair_val;
  logic              pair_hit;
  logic [DATA_W-1:0] sel;

  assign pair = addr[WORD_W-1:1];
  assign hi   = addr[0];

  always_comb begin
    pair_val = '0;
    pair_hit = 1'b0;
    for (int i = 0; i < NUM_MASKED; i++) begin
      if (pair == PAIR_W'(i)) begin
        pair_val = cfg[i];
        pair_hit = 1'b1;
      end
    end
    if (pair == PAIR_W'(PAIR_STAT)) begin pair_val = stat; pair_hit = 1'b1; end
    if (pair == PAIR_W'(PAIR_RAW))  begin pair_val = raw;  pair_hit = 1'b1; end
    if (pair == PAIR_W'(PAIR_EXT))  begin pair_val = ext;  pair_hit = 1'b1; end

    if (pair_hit)
      sel = hi ? {{HALF_W{1'b0}}, pair_val[DATA_W-1:HALF_W]}
               : {{HALF_W{1'b0}}, pair_val[HALF_W-1:0]};
    else if (addr == WORD_W'(WORD_DIV))
      sel = div;
    else if (addr == WORD_W'(WORD_VER))
      sel = VERSION_ID;
    else
      sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
    else            rd_data <= '0;
  end

  // R5: idle bus returns zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);
  // R6: version location reads the constant
  p_version_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == WORD_W'(WORD_VER)) |=> rd_data == 32'h0100_0C2B);
  // R4: masked halves never return bits above 15
  p_half_width_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(addr) < 2 * NUM_MASKED) |=> rd_data[DATA_W-1:HALF_W] == '0);
endmodule

// File: rtl/gpio_wm_bank.sv
module gpio_wm_bank
  import gpio_wm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] pin_in,
  input  logic [DATA_W-1:0] irq_status_in,
  input  logic [DATA_W-1:0] irq_raw_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_dir,
  output logic [DATA_W-1:0] irq_en,
  output logic [DATA_W-1:0] irq_mask,
  output logic [DATA_W-1:0] irq_type,
  output logic [DATA_W-1:0] irq_pol,
  output logic [DATA_W-1:0] irq_both,
  output logic [DATA_W-1:0] dbc_en,
  output logic [DATA_W-1:0] dbc_div_en,
  output logic [DATA_W-1:0] dbc_div,
  output logic [DATA_W-1:0] eoi_pulse
);
  cfg_arr_t          cfg;
  logic [PAIR_W-1:0] pair;
  logic              hi;
  logic [HALF_W-1:0] wmask;
  logic [HALF_W-1:0] wdat;

  assign pair  = addr[WORD_W-1:1];
  assign hi    = addr[0];
  assign wmask = wr_data[DATA_W-1:HALF_W];
  assign wdat  = wr_data[HALF_W-1:0];

  for (genvar i = 0; i < NUM_MASKED; i++) begin : g_reg
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic we_h;
      assign we_h = wr_en && (pair == PAIR_W'(i)) && (hi == h[0]);
      gpio_wm_half #(.W(HALF_W)) u_half (
        .clk  (clk),
        .rst  (rst),
        .we   (we_h),
        .mask (wmask),
        .data (wdat),
        .q    (cfg[i][h*HALF_W +: HALF_W])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     dbc_div <= '0;
    else if (wr_en && addr == WORD_W'(WORD_DIV)) dbc_div <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      eoi_pulse <= '0;
    else if (wr_en && pair == PAIR_W'(PAIR_EOI))
      eoi_pulse <= hi ? {wmask & wdat, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, wmask & wdat};
    else
      eoi_pulse <= '0;
  end

  assign pin_out    = cfg[IDX_OUT];
  assign pin_dir    = cfg[IDX_DIR];
  assign irq_en     = cfg[IDX_IEN];
  assign irq_mask   = cfg[IDX_IMSK];
  assign irq_type   = cfg[IDX_ITYP];
  assign irq_pol    = cfg[IDX_IPOL];
  assign irq_both   = cfg[IDX_IBOTH];
  assign dbc_en     = cfg[IDX_DBEN];
  assign dbc_div_en = cfg[IDX_DBDEN];

  gpio_wm_rdmux u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .cfg     (cfg),
    .div     (dbc_div),
    .stat    (irq_status_in),
    .raw     (irq_raw_in),
    .ext     (pin_in),
    .rd_data (rd_data)
  );

  // R8: divider takes the whole write word
  p_div_whole_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == WORD_W'(WORD_DIV)) |=> dbc_div == $past(wr_data));
  // R9: unmapped locations read zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !word_readable(int'(addr))) |=> rd_data == '0);
  // R7: upper external half reflects the pins
  p_ext_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 5'd29) |=> rd_data == {16'h0, $past(pin_in[31:16])});
  // R11: acknowledge lasts one cycle unless rewritten
  p_eoi_single_r11: assert property (@(posedge clk) disable iff (rst)
    (eoi_pulse != '0 && !wr_en) |=> eoi_pulse == '0);
  // R1: outputs cleared right after reset
  p_reset_outs_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_dir == '0 && irq_en == '0 && dbc_div == '0 && eoi_pulse == '0));
endmodule

// File: tb/gpio_wm_bank_tb.sv
module gpio_wm_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] irq_status_in = '0;
  logic [31:0] irq_raw_in = '0;
  logic [31:0] pin_out, pin_dir, irq_en, irq_mask, irq_type, irq_pol, irq_both;
  logic [31:0] dbc_en, dbc_div_en, dbc_div, eoi_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_wm_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .irq_status_in(irq_status_in), .irq_raw_in(irq_raw_in),
    .pin_out(pin_out), .pin_dir(pin_dir), .irq_en(irq_en), .irq_mask(irq_mask),
    .irq_type(irq_type), .irq_pol(irq_pol), .irq_both(irq_both),
    .dbc_en(dbc_en), .dbc_div_en(dbc_div_en), .dbc_div(dbc_div),
    .eoi_pulse(eoi_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive at a falling edge; the write commits at the following rising edge
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pin_dir", pin_dir, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq_en", irq_en, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    bus_read(5'd2, v);
    chk("R1 dir low half read", v, 32'h0);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    bus_write(5'd0, 32'hFFFF_A5A5);
    chk("R2 full enable write", pin_out, 32'h0000_A5A5);
    bus_write(5'd0, 32'h00F0_0030);
    chk("R2 partial enable", pin_out, 32'h0000_A535);
    bus_write(5'd0, 32'h0001_0000);
    chk("R3 single pin clear", pin_out, 32'h0000_A534);
    bus_write(5'd0, 32'h0000_FFFF);
    chk("R2 zero enables keep", pin_out, 32'h0000_A534);
    bus_read(5'd0, v);
    chk("R4 low half read", v, 32'h0000_A534);
  endtask

  task automatic t_high_and_cfg();
    logic [31:0] v;
    bus_write(5'd1, 32'hFFFF_1234);
    chk("R4 high half pins", pin_out, 32'h1234_A534);
    bus_read(5'd1, v);
    chk("R4 high half read", v, 32'h0000_1234);
    bus_write(5'd2, 32'h0003_0002);
    chk("R12 direction", pin_dir, 32'h0000_0002);
    bus_write(5'd8, 32'hFFFF_00FF);
    chk("R12 irq_type", irq_type, 32'h0000_00FF);
    bus_write(5'd17, 32'h8000_8000);
    chk("R12 dbc_div_en high", dbc_div_en, 32'h8000_0000);
    chk("R12 irq_pol untouched", irq_pol, 32'h0);
  endtask

  task automatic t_div();
    logic [31:0] v;
    bus_write(5'd18, 32'hDEAD_BEEF);
    chk("R8 divider write", dbc_div, 32'hDEAD_BEEF);
    bus_write(5'd18, 32'h0000_1234);
    chk("R8 no enable scheme", dbc_div, 32'h0000_1234);
    bus_read(5'd18, v);
    chk("R8 divider read", v, 32'h0000_1234);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    pin_in = 32'hCAFE_F00D;
    bus_read(5'd28, v);
    chk("R7 ext low", v, 32'h0000_F00D);
    bus_read(5'd29, v);
    chk("R7 ext high", v, 32'h0000_CAFE);
    bus_write(5'd28, 32'hFFFF_FFFF);
    bus_read(5'd28, v);
    chk("R7 ext ignores write", v, 32'h0000_F00D);
    bus_read(5'd30, v);
    chk("R6 version", v, 32'h0100_0C2B);
    bus_write(5'd30, 32'hFFFF_0000);
    bus_read(5'd30, v);
    chk("R6 version ignores write", v, 32'h0100_0C2B);
  endtask

  task automatic t_status();
    logic [31:0] v;
    irq_status_in = 32'h1111_2222;
    irq_raw_in    = 32'h3333_4444;
    bus_read(5'd20, v); chk("R10 status low", v, 32'h0000_2222);
    bus_read(5'd21, v); chk("R10 status high", v, 32'h0000_1111);
    bus_read(5'd22, v); chk("R10 raw low", v, 32'h0000_4444);
    bus_read(5'd23, v); chk("R10 raw high", v, 32'h0000_3333);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_read(5'd19, v); chk("R9 word 19", v, 32'h0);
    bus_read(5'd26, v); chk("R9 word 26", v, 32'h0);
    bus_read(5'd31, v); chk("R9 word 31", v, 32'h0);
  endtask

  task automatic t_eoi();
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; addr = 5'd25; wr_data = 32'h00FF_0F0F;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R11 pulse high half", eoi_pulse, 32'h000F_0000);
    @(negedge clk);
    chk("R11 pulse one cycle", eoi_pulse, 32'h0);
    bus_write(5'd24, 32'h0003_0001);
    chk("R11 pulse low half", eoi_pulse, 32'h0000_0001);
    bus_read(5'd24, v);
    chk("R11 eoi reads zero", v, 32'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R5 idle rd_data", rd_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masked();
    t_high_and_cfg();
    t_div();
    t_readonly();
    t_status();
    t_unmapped();
    t_eoi();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule